// File: doc/BRIEF.md
# GPIO Bank Register Interface

This block is the register front end for one bank of 32 general-purpose I/O lines, organised as four 8-bit ports named A, B, C and D. Line numbering runs A0..A7 as lines 0..7, then B as lines 8..15, C as lines 16..23 and D as lines 24..31. A simple 32-bit register bus reads and writes three registers: pin select, direction and data. Each register holds one bit per line. The block drives per-line output value, output enable and peripheral-select signals toward the pads. It samples the pin inputs through a synchronizer so that data reads return clean values.

Software sees each port as one byte lane of the bus word. Which lane a port occupies depends on a build-time port-order parameter. In the normal order, port A sits in the most significant byte of the word, which is the lowest byte address on a big-endian bus. In the reversed order, port A sits in the least significant byte. The stored state is always kept in line order, so the pads do not depend on the chosen ordering.

Top module: `gpio_bank_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the direction, pin-select and data registers clear. After reset, `pin_oe`, `pin_periph` and `pin_out` are all zero and every line is a GPIO input.
- R2: A line whose direction bit is 1 and whose pin-select bit is 0 has its `pin_oe` bit set. A direction bit of 0 leaves the line undriven. The direction register changes only on a bus write to offset 0x08.
- R3: `pin_periph` follows the pin-select register, written at offset 0x00. A line whose pin-select bit is 1 belongs to a peripheral and never has `pin_oe` set, whatever its direction bit.
- R4: With `PORT_REVERSED` = 0, bus bits [31:24] carry port A (lines 7..0), [23:16] port B, [15:8] port C and [7:0] port D. Within a byte, bit k is line k of that port. This holds for writes and reads of every register.
- R5: With `PORT_REVERSED` = 1, bus bits [7:0] carry port A, [15:8] port B, [23:16] port C and [31:24] port D.
- R6: A bus write to offset 0x0C loads the output value register, and that value appears on `pin_out` after the write edge. A data read returns the stored value for output lines.
- R7: A data read returns, for input lines, `pin_in` after a two-flop synchronizer. A pin change becomes visible to a read strobe two edges later. Read data appears on `bus_rdata` on the edge after `bus_rd` and holds until the next read.
- R8: A data write to a line that is an input stores the value without driving the pin. The stored value is driven once the line is switched to an output.
- R9: Reads of offsets 0x04, 0x10, 0x14, 0x18 and 0x1C return zero, and writes to them change no register.
- R10: Reads at offsets 0x00 and 0x08 return the pin-select and direction registers, with the lane order of R4/R5. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data returned next cycle |
| bus_addr | input | 5 | Byte address within the bank window |
| bus_wdata | input | 32 | Write data, ports in bus lane order |
| bus_rdata | output | 32 | Registered read data, ports in bus lane order |
| pin_in | input | 32 | Pin levels in line order, asynchronous |
| pin_out | output | 32 | Output values in line order |
| pin_oe | output | 32 | Output enables in line order |
| pin_periph | output | 32 | Per-line handover to the dedicated peripheral |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together and that the address is meaningful only while a strobe is high. They also assume that `pin_in` may change at any cycle, because the synchronizer absorbs it. The stimulus issues at most one strobe per cycle and changes pins only on the falling clock edge. Two instances, one per port order, receive the same bus traffic, so each lane mapping is checked against explicit byte-swapped expected words. Timing around the synchronizer is probed with back-to-back reads issued in the same cycle as a pin change.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants and register decode for the GPIO bank.
// Assumes word-aligned accesses; byte-address bits [1:0] are ignored.
package gpio_bank_pkg;

    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned WORD_IDX = ADDR_W - 2;

    typedef enum logic [1:0] {
        RS_NONE = 2'd0,
        RS_PSEL = 2'd1,
        RS_DIR  = 2'd2,
        RS_DATA = 2'd3
    } reg_sel_e;

    // Map a word index inside the bank window to a register.
    function automatic reg_sel_e reg_decode(input logic [WORD_IDX-1:0] widx);
        case (widx)
            3'd0:    return RS_PSEL;
            3'd2:    return RS_DIR;
            3'd3:    return RS_DATA;
            default: return RS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_lane_swap.sv
// Module: gpio_lane_swap
// Moves port bytes between line order (port 0 in the low byte) and bus
// lane order. The normal order mirrors the ports; the reversed order is
// the identity. Both are involutions, so one module serves both directions.
// Purely combinational.
module gpio_lane_swap #(
    parameter int unsigned PORTS    = 4,
    parameter int unsigned PORT_W   = 8,
    parameter bit          REVERSED = 1'b0,
    localparam int unsigned W       = PORTS * PORT_W
) (
    input  logic [W-1:0] src,
    output logic [W-1:0] dst
);

    // One byte move per port; the destination lane depends on the order.
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        localparam int unsigned LANE = REVERSED ? p : (PORTS - 1 - p);
        assign dst[LANE*PORT_W +: PORT_W] = src[p*PORT_W +: PORT_W];
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Multi-flop synchronizer for asynchronous pin levels. The output lags the
// input by STAGES clock edges. Assumes each bit is treated independently.
module gpio_in_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] chain [STAGES];

    // Stage 0 captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-times the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/gpio_reg_file.sv
// Module: gpio_reg_file
// Holds pin-select, direction and output-value registers in line order.
// Decodes bus accesses and registers read data. Assumes write data arrives
// already in line order and that rd/wr are never asserted together.
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int unsigned LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINES-1:0]  wr_line,
    input  logic [LINES-1:0]  pin_sync,
    output logic [LINES-1:0]  psel_q,
    output logic [LINES-1:0]  dir_q,
    output logic [LINES-1:0]  dout_q,
    output logic [LINES-1:0]  rd_line
);

    reg_sel_e         sel;
    logic [LINES-1:0] rd_mux;

    assign sel = reg_decode(addr[ADDR_W-1:2]);

    // Pin-select register: hands lines to the peripheral when set.
    always_ff @(posedge clk) begin
        if (!rst_n)                       psel_q <= '0;
        else if (wr_en && sel == RS_PSEL) psel_q <= wr_line;
    end

    // Direction register: 1 = output, 0 = input.
    always_ff @(posedge clk) begin
        if (!rst_n)                      dir_q <= '0;
        else if (wr_en && sel == RS_DIR) dir_q <= wr_line;
    end

    // Output value register: written regardless of direction.
    always_ff @(posedge clk) begin
        if (!rst_n)                       dout_q <= '0;
        else if (wr_en && sel == RS_DATA) dout_q <= wr_line;
    end

    // Read multiplexer: data merges stored outputs with sampled inputs.
    always_comb begin
        case (sel)
            RS_PSEL: rd_mux = psel_q;
            RS_DIR:  rd_mux = dir_q;
            RS_DATA: rd_mux = (dir_q & dout_q) | (~dir_q & pin_sync);
            default: rd_mux = '0;
        endcase
    end

    // Read data register: loads on a read strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_line <= '0;
        else if (rd_en) rd_line <= rd_mux;
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0 && psel_q == '0 && dout_q == '0));

    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == RS_DIR) |=> $stable(dir_q));

    p_rsvd_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == RS_NONE) |=> rd_line == '0);

    p_rsvd_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RS_NONE) |=>
            ($stable(psel_q) && $stable(dir_q) && $stable(dout_q)));

endmodule

// File: rtl/gpio_bank_regs.sv
// Module: gpio_bank_regs (top)
// Register interface for one 32-line GPIO bank of four 8-bit ports.
// PORT_REVERSED selects which bus byte lane each port occupies. Assumes a
// single-cycle strobe bus with no simultaneous read and write.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PORTS         = 4,
    parameter int unsigned PORT_W        = 8,
    parameter bit          PORT_REVERSED = 1'b0,
    parameter int unsigned SYNC_STAGES   = 2,
    localparam int unsigned LINES        = PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic [LINES-1:0]  pin_periph
);

    logic [LINES-1:0] wr_line;
    logic [LINES-1:0] rd_line;
    logic [LINES-1:0] pin_sync;
    logic [LINES-1:0] psel_q;
    logic [LINES-1:0] dir_q;
    logic [LINES-1:0] dout_q;

    gpio_lane_swap #(.PORTS(PORTS), .PORT_W(PORT_W), .REVERSED(PORT_REVERSED)) u_swap_wr (
        .src (bus_wdata),
        .dst (wr_line)
    );

    gpio_in_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    gpio_reg_file #(.LINES(LINES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .addr     (bus_addr),
        .wr_line  (wr_line),
        .pin_sync (pin_sync),
        .psel_q   (psel_q),
        .dir_q    (dir_q),
        .dout_q   (dout_q),
        .rd_line  (rd_line)
    );

    gpio_lane_swap #(.PORTS(PORTS), .PORT_W(PORT_W), .REVERSED(PORT_REVERSED)) u_swap_rd (
        .src (rd_line),
        .dst (bus_rdata)
    );

    // Pad drive: peripheral-owned lines are never driven by the GPIO path.
    assign pin_out    = dout_q;
    assign pin_oe     = dir_q & ~psel_q;
    assign pin_periph = psel_q;

    p_data_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && reg_decode(bus_addr[ADDR_W-1:2]) == RS_DATA) |=>
            pin_out == $past(wr_line));

    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/gpio_bank_regs_tb.sv
// Scoreboard bench: two instances, one per port order, on a shared bus.
module gpio_bank_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] rdata_n, out_n, oe_n, per_n;
    logic [31:0] rdata_r, out_r, oe_r, per_r;

    int total = 0;
    int fails = 0;

    logic [31:0] exp_n_q[$];
    logic [31:0] exp_r_q[$];
    string       tag_q[$];
    logic        rd_d = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    gpio_bank_regs #(.PORT_REVERSED(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_n),
        .pin_in(pin_in), .pin_out(out_n), .pin_oe(oe_n), .pin_periph(per_n)
    );

    gpio_bank_regs #(.PORT_REVERSED(1'b1)) u_dut_rev (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_r),
        .pin_in(pin_in), .pin_out(out_r), .pin_oe(oe_r), .pin_periph(per_r)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Driver: one-cycle write, aligned to falling edges.
    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: one-cycle read strobe; expected words go to the scoreboard.
    task automatic do_read(input logic [4:0] a, input logic [31:0] en,
                           input logic [31:0] er, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        exp_n_q.push_back(en); exp_r_q.push_back(er); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: notes which cycles carried a read strobe.
    always @(posedge clk) rd_d <= bus_rd;

    // Monitor: compares returned read data against the queue.
    always @(negedge clk) begin
        if (rd_d && exp_n_q.size() > 0) begin
            string t;
            t = tag_q.pop_front();
            check({t, " normal"},   rdata_n, exp_n_q.pop_front());
            check({t, " reversed"}, rdata_r, exp_r_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 oe", oe_n, 32'h0);   check("R1 oe rev", oe_r, 32'h0);
        check("R1 periph", per_n, 32'h0); check("R1 out", out_n, 32'h0);
        do_read(5'h08, 32'h0, 32'h0, "R1 dir read");

        // R2/R4/R5: low bus byte is port D (normal) or port A (reversed)
        do_write(5'h08, 32'h0000_00FF);
        check("R2 R4 oe normal", oe_n, 32'hFF00_0000);
        check("R2 R5 oe reversed", oe_r, 32'h0000_00FF);
        do_read(5'h08, 32'h0000_00FF, 32'h0000_00FF, "R10 dir read");
        do_read(5'h0B, 32'h0000_00FF, 32'h0000_00FF, "R10 unaligned dir read");

        // R6/R4/R5: data write lane mapping
        do_write(5'h0C, 32'hA5C3_0F81);
        check("R6 R4 out normal", out_n, 32'h810F_C3A5);
        check("R6 R5 out reversed", out_r, 32'hA5C3_0F81);
        // R8: input lines hold the stored value but stay undriven
        check("R8 oe normal", oe_n, 32'hFF00_0000);
        check("R8 oe reversed", oe_r, 32'h0000_00FF);

        // R7: mixed data read, outputs from register, inputs from pins
        pin_in = 32'h1234_5678;
        repeat (3) @(negedge clk);
        do_read(5'h0C, 32'h7856_3481, 32'h1234_5681, "R7 mixed data read");

        // R8: switching to output drives the earlier stored value
        do_write(5'h08, 32'hFFFF_FFFF);
        check("R8 oe all", oe_n, 32'hFFFF_FFFF);
        check("R8 out kept", out_n, 32'h810F_C3A5);
        do_read(5'h0C, 32'hA5C3_0F81, 32'hA5C3_0F81, "R8 data readback");

        // R3: pin select hands a line to the peripheral
        do_write(5'h00, 32'h0000_0001);
        check("R3 periph normal", per_n, 32'h0100_0000);
        check("R3 periph reversed", per_r, 32'h0000_0001);
        check("R3 oe normal", oe_n, 32'hFEFF_FFFF);
        check("R3 oe reversed", oe_r, 32'hFFFF_FFFE);
        do_read(5'h00, 32'h0000_0001, 32'h0000_0001, "R10 psel read");

        // R9: unmapped offsets
        for (int i = 0; i < 5; i++) begin
            logic [4:0] a;
            a = (i == 0) ? 5'h04 : 5'(5'h10 + 4 * (i - 1));
            do_write(a, 32'hFFFF_FFFF);
            check("R9 write ignored oe", oe_n, 32'hFEFF_FFFF);
            check("R9 write ignored periph", per_n, 32'h0100_0000);
            check("R9 write ignored out", out_n, 32'h810F_C3A5);
            do_read(a, 32'h0, 32'h0, "R9 unmapped read");
        end
        do_read(5'h00, 32'h0000_0001, 32'h0000_0001, "R9 psel intact");

        // R7: all inputs, full-word pin pattern and synchronizer latency
        do_write(5'h00, 32'h0);
        do_write(5'h08, 32'h0);
        check("R2 oe cleared", oe_n, 32'h0);
        pin_in = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        do_read(5'h0C, 32'hEFBE_ADDE, 32'hDEAD_BEEF, "R7 input read");
        pin_in = 32'h0;
        do_read(5'h0C, 32'hEFBE_ADDE, 32'hDEAD_BEEF, "R7 latency edge 1");
        do_read(5'h0C, 32'hEFBE_ADDE, 32'hDEAD_BEEF, "R7 latency edge 2");
        do_read(5'h0C, 32'h0, 32'h0, "R7 new value");
        repeat (2) @(negedge clk);
        check("R7 rdata holds", rdata_n, 32'h0);

        // R1: reset again clears state
        rst_n = 1'b0;
        do_write(5'h08, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after reset", oe_n, 32'h0);
        check("R1 out after reset", out_r, 32'h0);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule